// File: doc/BRIEF.md
# Per-Phase PWM Gate Controller with Non-Overlap Timing

This block holds the switching state of one converter phase. A falling edge on the phase clock input turns the phase on. An asserted comparator trip turns it off. The block drives two complementary gate enables, one for the high-side switch and one for the low-side switch. Each transition first removes the switch that is conducting. Both enables then stay low for a programmable number of fast-clock cycles before the other switch is enabled. A ramp-discharge enable is high whenever the phase is in its off (latch-clear) condition.

The block is built around a five-state machine. **IDLE** is the state after reset: both switches are off and the latch is clear. **GAP_ON** is the non-overlap wait before the high side turns on, with the latch set. **HIGH** means the high side is conducting. **GAP_OFF** is the non-overlap wait before the low side turns on, with the latch clear. **LOW** means the low side is conducting.

The transitions are as follows:
- *set*: IDLE, GAP_OFF or LOW go to GAP_ON on a qualified falling edge.
- *gap_on_done*: GAP_ON goes to HIGH.
- *trip_off*: HIGH or GAP_ON go to GAP_OFF when trip is asserted.
- *gap_off_done*: GAP_OFF goes to LOW.

All other conditions keep the current state. The trip, the ramp and the error amplifier are analog functions outside this block and arrive here as synchronous digital levels.

Top module: `pwm_gate_ctrl`

## Requirements
- R1: While and directly after reset, hs_en=0, ls_en=0 and rdis_en=1.
- R2: A falling edge of phase_clk sets the latch when trip is low. A falling edge means phase_clk was 1 at the previous clock edge and is 0 at this one. On the next clock edge rdis_en and ls_en go to 0.
- R3: After a set, both enables stay low for dead_cycles+1 clock cycles, and then hs_en goes to 1.
- R4: When trip is 1 while hs_en=1, hs_en goes to 0 and rdis_en goes to 1 on the next clock edge. ls_en goes to 1 after dead_cycles+1 cycles with both enables low.
- R5: Reset dominance: when trip=1 in the same cycle as a falling edge, the latch stays clear. After any cycle with trip=1, rdis_en=1.
- R6: While trip stays 0, hs_en stays 1 through any number of further phase_clk edges, giving 100% duty.
- R7: Without a falling edge, the latch never sets, whether phase_clk is held low or held high.
- R8: hs_en and ls_en are never 1 in the same cycle.
- R9: rdis_en is the inverse of the latch. It is 0 whenever hs_en=1 and 1 whenever ls_en=1.
- R10: A trip during the turn-on gap cancels the turn-on: hs_en never rises, and ls_en rises after dead_cycles+1 cycles.
- R11: dead_cycles is sampled when a gap starts. Changing it during a gap does not change the length of that gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock that counts the non-overlap time |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_clk | input | 1 | Phase clock pulse, synchronous to clk; its falling edge sets the latch |
| trip | input | 1 | PWM comparator trip; clears the latch and wins over a set |
| dead_cycles | input | 4 | Non-overlap setting; the gap lasts dead_cycles+1 cycles |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| rdis_en | output | 1 | Ramp-discharge enable, high while the latch is clear |

## Verification
The hardest case to reach is a trip that lands inside the turn-on gap. It must arrive after a falling edge has set the latch but before hs_en rises. The stimulus produces it by asserting trip on the first cycle after a set, with dead_cycles=1, so the trip falls into the two-cycle gap. The reset-dominant collision is also hard to reach. The stimulus produces it by raising trip exactly on the cycle of a falling edge while the phase is sitting in LOW. Gap lengths at both ends of the dead_cycles range are measured by counting cycles at the ports. A separate case changes dead_cycles one cycle into a gap to confirm that the value is captured when the gap starts.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_GAP_ON  = 3'd1,
        ST_HIGH    = 3'd2,
        ST_GAP_OFF = 3'd3,
        ST_LOW     = 3'd4
    } gate_state_t;
endpackage

// File: rtl/pwm_fall_detect.sv
module pwm_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_in,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pulse_in;
    end

    // high on the previous edge, low now
    assign fall = prev_q & ~pulse_in;
endmodule

// File: rtl/pwm_gap_timer.sv
module pwm_gap_timer #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [DT_W-1:0] length,
    output logic            done
);
    logic [DT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= length;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pwm_gate_fsm.sv
module pwm_gate_fsm
    import pwm_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic trip,
    input  logic gap_done,
    output logic gap_load,
    output logic hs_en,
    output logic ls_en,
    output logic rdis_en
);
    gate_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (set_req) state_d = ST_GAP_ON;
            ST_GAP_ON: begin
                if (trip)          state_d = ST_GAP_OFF;
                else if (gap_done) state_d = ST_HIGH;
            end
            ST_HIGH:    if (trip) state_d = ST_GAP_OFF;
            ST_GAP_OFF: begin
                if (set_req)       state_d = ST_GAP_ON;
                else if (gap_done) state_d = ST_LOW;
            end
            ST_LOW:     if (set_req) state_d = ST_GAP_ON;
            default:    state_d = ST_IDLE;
        endcase
    end

    assign gap_load = (state_d != state_q) &&
                      ((state_d == ST_GAP_ON) || (state_d == ST_GAP_OFF));

    always_comb begin
        hs_en   = 1'b0;
        ls_en   = 1'b0;
        rdis_en = 1'b1;
        unique case (state_q)
            ST_IDLE:    ;
            ST_GAP_ON:  rdis_en = 1'b0;
            ST_HIGH: begin
                hs_en   = 1'b1;
                rdis_en = 1'b0;
            end
            ST_GAP_OFF: ;
            ST_LOW:     ls_en = 1'b1;
            default:    ;
        endcase
    end
endmodule

// File: rtl/pwm_gate_ctrl.sv
module pwm_gate_ctrl #(
    parameter int DT_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            phase_clk,
    input  logic            trip,
    input  logic [DT_W-1:0] dead_cycles,
    output logic            hs_en,
    output logic            ls_en,
    output logic            rdis_en
);
    logic fall;
    logic set_req;
    logic gap_load;
    logic gap_done;

    pwm_fall_detect u_fall (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse_in (phase_clk),
        .fall     (fall)
    );

    // reset-dominant: a trip masks the set
    assign set_req = fall & ~trip;

    pwm_gap_timer #(.DT_W(DT_W)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (gap_load),
        .length (dead_cycles),
        .done   (gap_done)
    );

    pwm_gate_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_req  (set_req),
        .trip     (trip),
        .gap_done (gap_done),
        .gap_load (gap_load),
        .hs_en    (hs_en),
        .ls_en    (ls_en),
        .rdis_en  (rdis_en)
    );
endmodule

// File: rtl/pwm_gate_ctrl_chk.sv
module pwm_gate_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic phase_clk,
    input logic trip,
    input logic hs_en,
    input logic ls_en,
    input logic rdis_en
);
    p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    p_hs_latch_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hs_en |-> !rdis_en);

    p_ls_latch_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ls_en |-> rdis_en);

    p_trip_cuts_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && trip) |=> !hs_en);

    p_trip_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trip |=> rdis_en);

    p_full_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en && !trip) |=> hs_en);

    p_no_set_without_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdis_en && !($past(phase_clk) && !phase_clk)) |=> rdis_en);

    p_hs_after_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(!ls_en && !rdis_en));

    p_ls_after_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> $past(!hs_en && rdis_en));
endmodule

bind pwm_gate_ctrl pwm_gate_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_clk (phase_clk),
    .trip      (trip),
    .hs_en     (hs_en),
    .ls_en     (ls_en),
    .rdis_en   (rdis_en)
);

// File: tb/pwm_gate_ctrl_tb.sv
module pwm_gate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phase_clk = 1'b0;
    logic       trip = 1'b0;
    logic [3:0] dead_cycles = 4'd1;
    logic       hs_en, ls_en, rdis_en;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_gate_ctrl u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .phase_clk   (phase_clk),
        .trip        (trip),
        .dead_cycles (dead_cycles),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .rdis_en     (rdis_en)
    );

    // {phase_clk, trip, exp_hs, exp_ls, exp_rdis}; dead_cycles = 1 (gap = 2 cycles)
    localparam logic [4:0] VEC [NVEC] = '{
        5'b10_001, // 0  R7 high, no edge yet
        5'b00_000, // 1  R2 falling edge sets
        5'b00_000, // 2  R3 gap
        5'b00_100, // 3  R3 high side on
        5'b10_100, // 4  R6
        5'b00_100, // 5  R6 new edge keeps high
        5'b01_001, // 6  R4 trip drops high
        5'b00_001, // 7  R4 gap
        5'b00_011, // 8  R4 low side on
        5'b10_011, // 9  R7 high held
        5'b01_011, // 10 R5 edge with trip stays clear
        5'b10_011, // 11 R7
        5'b00_000, // 12 R2 set from LOW
        5'b01_001, // 13 R10 trip in turn-on gap
        5'b00_001, // 14 R10 gap
        5'b00_011, // 15 R10 low side on
        5'b00_011  // 16 R7 held low, no new edge
    };
    localparam int VREQ [NVEC] = '{7,2,3,3,6,6,4,4,4,7,5,7,2,10,10,10,7};

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {hs,ls,rdis} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; phase_clk = 1'b0; trip = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // set the latch with gap length d, return cycles until hs_en rises
    task automatic measure_on(input logic [3:0] d, input logic [3:0] d_later, output int n);
        phase_clk = 1'b1;
        @(negedge clk);
        phase_clk = 1'b0; dead_cycles = d;
        n = 0;
        @(negedge clk);
        dead_cycles = d_later;
        while (!hs_en && n < 40) begin
            n++;
            if (ls_en) check("R3 ls during gap", {hs_en, ls_en, rdis_en}, 3'b000);
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        // R1 reset state
        @(negedge clk);
        check("R1 in reset", {hs_en, ls_en, rdis_en}, 3'b001);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 after reset", {hs_en, ls_en, rdis_en}, 3'b001);

        for (int i = 0; i < NVEC; i++) begin
            phase_clk = VEC[i][4];
            trip      = VEC[i][3];
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VREQ[i], i),
                  {hs_en, ls_en, rdis_en}, VEC[i][2:0]);
        end

        // R3 minimum gap
        do_reset();
        measure_on(4'd0, 4'd0, n);
        check($sformatf("R3 gap d=0 cycles=%0d", n), 3'(n), 3'd1);
        // R3 maximum gap
        do_reset();
        measure_on(4'd15, 4'd15, n);
        n_tests++;
        if (n != 16) begin
            n_fail++;
            $display("FAIL R3 gap d=15: actual=%0d expected=16", n);
        end
        // R4 off gap length with d=3
        dead_cycles = 4'd3;
        trip = 1'b1;
        @(negedge clk);
        trip = 1'b0;
        n = 1;
        while (!ls_en && n < 40) begin
            @(negedge clk);
            n++;
        end
        check($sformatf("R4 off gap d=3 cycles=%0d", n), 3'(n), 3'd5);
        // R11 change during gap ignored
        do_reset();
        measure_on(4'd5, 4'd0, n);
        check($sformatf("R11 gap d=5 changed cycles=%0d", n), 3'(n), 3'd6);
        // R1 mid-operation reset
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset from HIGH", {hs_en, ls_en, rdis_en}, 3'b001);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule